// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

This block collects a wide set of peripheral interrupt lines and folds them onto a small number of CPU interrupt request lines. By default 96 sources are arranged as 12 groups of 8, and each group owns one CPU request line. Each source has a flag and an enable bit. A rising edge on a source line latches its flag. When a flagged source is also enabled, the group sends a single one-cycle pulse to the CPU. The group then stays silent until software writes 1 to that group's acknowledge bit.

When the CPU takes a group interrupt, it raises a one-cycle fetch strobe together with the group number. In that same cycle the block finds the lowest-numbered source in the group that is both flagged and enabled. It returns that source's vector table address and clears the source's flag at the end of the cycle. The returned address is also kept, and its upper bits can be read back through the control register. Bit 0 of the control register chooses between two paths. With the bit set, fetches are served from the expansion table. With the bit clear, the block is bypassed and the normal vector path is used. Software reaches every register through a plain single-cycle write port and a combinational read port.

Top module: `grp_irq_expander`

## Requirements
- R1: After a synchronous reset, every register reads 0 and no CPU request line is high.
- R2: A source flag is set by a 0-to-1 transition of its line. A line held high does not set the flag again once the flag has been cleared.
- R3: A register write to a group's flag word loads bits 7:0: written 0s clear flags and written 1s set them. A rising source edge in the same cycle as a write of 0 to its flag leaves the flag set. Flag bits 15:8 read 0.
- R4: A group's enable word stores bits 7:0 and reads bits 15:8 as 0. A flagged source whose enable bit is 0 does not cause a request.
- R5: The first clock edge that sees a group with a flagged and enabled source, while the group is not blocked, drives that group's CPU line high for exactly one cycle. From then on the group's acknowledge bit reads 1.
- R6: While a group's acknowledge bit reads 1, no further pulse leaves on that line. Writing 0 to an acknowledge bit has no effect. Writing 1 releases the group, and if a source is still pending the next pulse follows one edge later.
- R7: In the cycle of a fetch strobe with the table path selected, fetch_hit is 1 exactly when the named group has a flagged and enabled source. fetch_vector is VEC_BASE + VEC_OFFSET + 2 × (group × 8 + index), where index is the lowest such source (default base 0x0D00, offset 0x40).
- R8: A fetch hit clears only the winning source's flag, at the end of the fetch cycle. The other flags in the group keep their values.
- R9: Control bit 0 resets to 0 and drives table_sel. While it is 0, a fetch strobe gives fetch_hit = 0 and changes no flag and no register.
- R10: Control bits 15:1 read back bits 15:1 of the most recent hit's vector address. Writes to those bits have no effect.
- R11: Register word addresses are: control at 0, acknowledge at 1 (bit g = group g, bits 15:12 read 0), enable of group g at 2 + 2g, flag of group g at 3 + 2g. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | 96 | Source lines, group g uses bits 8g+7 down to 8g |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| cpu_irq | output | 12 | One-cycle request pulse per group |
| fetch_strobe | input | 1 | One-cycle vector fetch request from the CPU |
| fetch_group | input | 4 | Group being fetched, 0 to 11 |
| fetch_hit | output | 1 | A source was found for this fetch |
| fetch_vector | output | 16 | Vector table address of the winning source |
| table_sel | output | 1 | 1 when vectors come from the expansion table |

## Verification
The assertions assume that the CPU raises the fetch strobe only for a group number below 12. They also assume that the table base and offset are even, because the range-and-alignment property relies on it. Finally they assume that the source lines are already synchronous to the clock. The stimulus meets all three: it fetches only valid groups, keeps the default even base and offset, and changes source lines only just after a clock edge. The pulse and blocking properties need no assumption about software timing, so the acknowledge writes are placed freely, including while a group is still blocked.

// File: rtl/gie_pkg.sv
// Package gie_pkg
// Shared register address layout for the grouped interrupt expander.
// Assumes word addressing with one register per address.
package gie_pkg;
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_ACK      = 1;
    localparam int ADDR_GRP_BASE = 2;

    // Word address of the enable register of group g.
    function automatic int grp_en_addr(input int g);
        return ADDR_GRP_BASE + 2 * g;
    endfunction

    // Word address of the flag register of group g.
    function automatic int grp_flag_addr(input int g);
        return ADDR_GRP_BASE + 2 * g + 1;
    endfunction
endpackage

// File: rtl/irq_group_slice.sv
// Module irq_group_slice
// One interrupt group: edge-detects its sources, holds flag and enable bits,
// and emits a single request pulse that stays blocked until released.
// Assumes source lines are synchronous to clk.
module irq_group_slice #(
    parameter int SRCS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SRCS-1:0] src_in,
    input  logic            en_wr,
    input  logic            flag_wr,
    input  logic [SRCS-1:0] wdata,
    input  logic [SRCS-1:0] fetch_clr,
    input  logic            ack_release,
    output logic [SRCS-1:0] en_q,
    output logic [SRCS-1:0] flag_q,
    output logic [SRCS-1:0] pend,
    output logic            blocked_q,
    output logic            irq_pulse_q
);
    logic [SRCS-1:0] src_d;
    logic [SRCS-1:0] rise;
    logic            issue;

    assign rise  = src_in & ~src_d;
    assign pend  = flag_q & en_q;
    assign issue = (|pend) && !blocked_q;

    // Remember the previous source levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_d <= '0;
        else        src_d <= src_in;
    end

    // Enable bits are plain software storage.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wdata;
    end

    // Flags: a rising edge wins over a software write or a fetch clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= '0;
        else if (flag_wr) flag_q <= wdata | rise;
        else              flag_q <= (flag_q & ~fetch_clr) | rise;
    end

    // Request pulse and blocking state; a pulse always re-blocks the group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse_q <= 1'b0;
            blocked_q   <= 1'b0;
        end else begin
            irq_pulse_q <= issue;
            if (issue)            blocked_q <= 1'b1;
            else if (ack_release) blocked_q <= 1'b0;
        end
    end
endmodule

// File: rtl/vec_fetch_unit.sv
// Module vec_fetch_unit
// Combinational vector fetch: selects the fetched group's pending sources,
// finds the lowest-numbered one, forms its table address and a one-hot clear.
// Assumes fetch_group names a valid group; others return no hit.
module vec_fetch_unit #(
    parameter int             NG         = 12,
    parameter int             SRCS       = 8,
    parameter int             DW         = 16,
    parameter logic [DW-1:0]  VEC_BASE   = 16'h0D00,
    parameter logic [DW-1:0]  VEC_OFFSET = 16'h0040,
    localparam int            GW         = $clog2(NG),
    localparam int            TOT        = NG * SRCS,
    localparam int            LW         = $clog2(TOT),
    localparam int            IW         = $clog2(SRCS)
) (
    input  logic            fetch_strobe,
    input  logic [GW-1:0]   fetch_group,
    input  logic            table_en,
    input  logic [TOT-1:0]  pend_all,
    output logic            hit,
    output logic [DW-1:0]   vector,
    output logic [TOT-1:0]  clr_all
);
    logic [SRCS-1:0] sel_pend;
    logic [IW-1:0]   win_idx;
    logic            found;
    logic [LW-1:0]   lin_idx;

    // Pick the pending vector of the requested group.
    always_comb begin
        sel_pend = '0;
        for (int g = 0; g < NG; g++) begin
            if (fetch_group == GW'(g)) sel_pend = pend_all[g*SRCS +: SRCS];
        end
    end

    // Lowest-numbered pending source wins; scan from the top down.
    always_comb begin
        win_idx = '0;
        found   = 1'b0;
        for (int i = SRCS - 1; i >= 0; i--) begin
            if (sel_pend[i]) begin
                win_idx = IW'(i);
                found   = 1'b1;
            end
        end
    end

    assign hit     = fetch_strobe && table_en && found;
    assign lin_idx = LW'(fetch_group) * LW'(SRCS) + LW'(win_idx);
    assign vector  = VEC_BASE + VEC_OFFSET + (DW'(lin_idx) << 1);
    assign clr_all = hit ? (TOT'(1) << lin_idx) : '0;
endmodule

// File: rtl/gie_reg_port.sv
// Module gie_reg_port
// Decodes register writes into per-group strobes and muxes read data.
// Assumes single-cycle writes and combinational reads; unmapped reads give 0.
module gie_reg_port #(
    parameter int NG   = 12,
    parameter int SRCS = 8,
    parameter int DW   = 16,
    parameter int RAW  = 5
) (
    input  logic                      reg_wr,
    input  logic [RAW-1:0]            reg_addr,
    input  logic [NG-1:0]             ack_bits,
    input  logic                      ctrl_en,
    input  logic [DW-2:0]             last_vec,
    input  logic [NG-1:0][SRCS-1:0]   en_arr,
    input  logic [NG-1:0][SRCS-1:0]   flag_arr,
    input  logic [NG-1:0]             blocked,
    output logic                      ctrl_wr,
    output logic [NG-1:0]             en_wr,
    output logic [NG-1:0]             flag_wr,
    output logic [NG-1:0]             ack_rel,
    output logic [DW-1:0]             rdata
);
    import gie_pkg::*;

    assign ctrl_wr = reg_wr && (reg_addr == RAW'(ADDR_CTRL));

    // Per-group write strobes and write-1 release of the acknowledge bits.
    for (genvar g = 0; g < NG; g++) begin : g_dec
        assign en_wr[g]   = reg_wr && (reg_addr == RAW'(grp_en_addr(g)));
        assign flag_wr[g] = reg_wr && (reg_addr == RAW'(grp_flag_addr(g)));
        assign ack_rel[g] = reg_wr && (reg_addr == RAW'(ADDR_ACK)) && ack_bits[g];
    end

    // Read multiplexer; narrow registers are zero-extended.
    always_comb begin
        rdata = '0;
        if (reg_addr == RAW'(ADDR_CTRL)) rdata = {last_vec, ctrl_en};
        if (reg_addr == RAW'(ADDR_ACK))  rdata[NG-1:0] = blocked;
        for (int g = 0; g < NG; g++) begin
            if (reg_addr == RAW'(grp_en_addr(g)))   rdata[SRCS-1:0] = en_arr[g];
            if (reg_addr == RAW'(grp_flag_addr(g))) rdata[SRCS-1:0] = flag_arr[g];
        end
    end
endmodule

// File: rtl/grp_irq_expander.sv
// Module grp_irq_expander
// Top level: NG groups of SRCS sources fanned into NG pulsed CPU requests,
// with a vector fetch path and a small register file.
// Assumes NG <= DW, SRCS <= DW, synchronous inputs, even base and offset.
module grp_irq_expander #(
    parameter int             NG         = 12,
    parameter int             SRCS       = 8,
    parameter int             DW         = 16,
    parameter logic [DW-1:0]  VEC_BASE   = 16'h0D00,
    parameter logic [DW-1:0]  VEC_OFFSET = 16'h0040,
    localparam int            GW         = $clog2(NG),
    localparam int            TOT        = NG * SRCS,
    localparam int            RAW        = $clog2(2 + 2 * NG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOT-1:0]    src_irq,
    input  logic              reg_wr,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [NG-1:0]     cpu_irq,
    input  logic              fetch_strobe,
    input  logic [GW-1:0]     fetch_group,
    output logic              fetch_hit,
    output logic [DW-1:0]     fetch_vector,
    output logic              table_sel
);
    logic                    ctrl_en_q;
    logic [DW-2:0]           last_vec_q;
    logic                    ctrl_wr;
    logic [NG-1:0]           en_wr;
    logic [NG-1:0]           flag_wr;
    logic [NG-1:0]           ack_rel;
    logic [NG-1:0]           blocked;
    logic [NG-1:0][SRCS-1:0] en_arr;
    logic [NG-1:0][SRCS-1:0] flag_arr;
    logic [TOT-1:0]          pend_all;
    logic [TOT-1:0]          clr_all;
    logic                    wdata_unused;

    assign wdata_unused = ^reg_wdata[DW-1:NG];
    assign table_sel    = ctrl_en_q;

    gie_reg_port #(.NG(NG), .SRCS(SRCS), .DW(DW), .RAW(RAW)) u_regs (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .ack_bits (reg_wdata[NG-1:0]),
        .ctrl_en  (ctrl_en_q),
        .last_vec (last_vec_q),
        .en_arr   (en_arr),
        .flag_arr (flag_arr),
        .blocked  (blocked),
        .ctrl_wr  (ctrl_wr),
        .en_wr    (en_wr),
        .flag_wr  (flag_wr),
        .ack_rel  (ack_rel),
        .rdata    (reg_rdata)
    );

    for (genvar g = 0; g < NG; g++) begin : g_grp
        irq_group_slice #(.SRCS(SRCS)) u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_in      (src_irq[g*SRCS +: SRCS]),
            .en_wr       (en_wr[g]),
            .flag_wr     (flag_wr[g]),
            .wdata       (reg_wdata[SRCS-1:0]),
            .fetch_clr   (clr_all[g*SRCS +: SRCS]),
            .ack_release (ack_rel[g]),
            .en_q        (en_arr[g]),
            .flag_q      (flag_arr[g]),
            .pend        (pend_all[g*SRCS +: SRCS]),
            .blocked_q   (blocked[g]),
            .irq_pulse_q (cpu_irq[g])
        );
    end

    vec_fetch_unit #(
        .NG(NG), .SRCS(SRCS), .DW(DW), .VEC_BASE(VEC_BASE), .VEC_OFFSET(VEC_OFFSET)
    ) u_fetch (
        .fetch_strobe (fetch_strobe),
        .fetch_group  (fetch_group),
        .table_en     (ctrl_en_q),
        .pend_all     (pend_all),
        .hit          (fetch_hit),
        .vector       (fetch_vector),
        .clr_all      (clr_all)
    );

    // Control enable bit, software writable.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_en_q <= 1'b0;
        else if (ctrl_wr) ctrl_en_q <= reg_wdata[0];
    end

    // Keep bits DW-1:1 of the last served vector address.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_vec_q <= '0;
        else if (fetch_hit) last_vec_q <= fetch_vector[DW-1:1];
    end
endmodule

// File: rtl/gie_checker.sv
// Module gie_checker
// Temporal properties of the expander, bound to the top module.
// Assumes fetches name valid groups and base plus offset is even.
module gie_checker #(
    parameter int             NG         = 12,
    parameter int             SRCS       = 8,
    parameter int             DW         = 16,
    parameter logic [DW-1:0]  VEC_BASE   = 16'h0D00,
    parameter logic [DW-1:0]  VEC_OFFSET = 16'h0040
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NG-1:0] cpu_irq,
    input logic          fetch_strobe,
    input logic          fetch_hit,
    input logic [DW-1:0] fetch_vector,
    input logic          table_sel,
    input logic [DW-2:0] last_vec_q
);
    localparam logic [DW-1:0] VEC_LO = VEC_BASE + VEC_OFFSET;
    localparam logic [DW-1:0] VEC_HI = VEC_LO + DW'(2 * (NG * SRCS - 1));

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (cpu_irq == '0));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq != '0) |=> ((cpu_irq & $past(cpu_irq)) == '0));

    p_hit_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> fetch_strobe);

    p_vec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> (fetch_vector >= VEC_LO && fetch_vector <= VEC_HI && !fetch_vector[0]));

    p_bypass_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_strobe && !table_sel) |-> !fetch_hit);

    p_last_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |=> (last_vec_q == $past(fetch_vector[DW-1:1])));
endmodule

bind grp_irq_expander gie_checker #(
    .NG(NG), .SRCS(SRCS), .DW(DW), .VEC_BASE(VEC_BASE), .VEC_OFFSET(VEC_OFFSET)
) u_gie_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_irq      (cpu_irq),
    .fetch_strobe (fetch_strobe),
    .fetch_hit    (fetch_hit),
    .fetch_vector (fetch_vector),
    .table_sel    (table_sel),
    .last_vec_q   (last_vec_q)
);

// File: tb/tb_grp_irq_expander.sv
`timescale 1ns/1ps
module tb_grp_irq_expander;
    localparam int NG = 12;
    localparam int SRCS = 8;
    localparam logic [15:0] VEC0 = 16'h0D40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NG*SRCS-1:0] src_irq = '0;
    logic              reg_wr = 1'b0;
    logic [4:0]        reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic [NG-1:0]     cpu_irq;
    logic              fetch_strobe = 1'b0;
    logic [3:0]        fetch_group = '0;
    logic              fetch_hit;
    logic [15:0]       fetch_vector;
    logic              table_sel;

    int n_chk = 0;
    int n_bad = 0;
    int pulse_cnt [NG];
    bit done = 1'b0;

    always #2 clk = ~clk;

    grp_irq_expander dut (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_irq(cpu_irq), .fetch_strobe(fetch_strobe), .fetch_group(fetch_group),
        .fetch_hit(fetch_hit), .fetch_vector(fetch_vector), .table_sel(table_sel)
    );

    // Count request pulses per group, sampled mid-cycle.
    always @(negedge clk) begin
        for (int g = 0; g < NG; g++) if (cpu_irq[g]) pulse_cnt[g]++;
    end

    // Stimulus table: group, raised sources, enable mask, expected winner.
    localparam logic [22:0] TBL [0:7] = '{
        {4'd0,  8'h01, 8'hFF, 3'd0},
        {4'd0,  8'h80, 8'hFF, 3'd7},
        {4'd3,  8'h0C, 8'hFF, 3'd2},
        {4'd5,  8'hF0, 8'h60, 3'd5},
        {4'd11, 8'h81, 8'h80, 3'd7},
        {4'd7,  8'hAA, 8'hFF, 3'd1},
        {4'd11, 8'hFF, 8'hFF, 3'd0},
        {4'd2,  8'h10, 8'h10, 3'd4}
    };

    function automatic logic [15:0] exp_vec(input int g, input int i);
        return VEC0 + 16'(2 * (g * SRCS + i));
    endfunction

    function automatic logic [4:0] a_en(input int g);
        return 5'(2 + 2 * g);
    endfunction

    function automatic logic [4:0] a_fl(input int g);
        return 5'(3 + 2 * g);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
        tick();
    endtask

    task automatic fetch(input int g, output logic h, output logic [15:0] v);
        fetch_strobe = 1'b1; fetch_group = 4'(g);
        #0.5;
        h = fetch_hit; v = fetch_vector;
        tick();
        fetch_strobe = 1'b0;
    endtask

    task automatic raise(input int g, input logic [7:0] m);
        src_irq[g*SRCS +: SRCS] = m;
        tick();
        src_irq[g*SRCS +: SRCS] = '0;
    endtask

    task automatic clr_pulses();
        for (int g = 0; g < NG; g++) pulse_cnt[g] = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic h;
        logic [15:0] v;
        clr_pulses();
        tick(); tick();
        // R1 reset state
        chk("R1 cpu_irq", 32'(cpu_irq), 0);
        rst_n = 1'b1;
        rd(5'd0, d);  chk("R1 ctrl", 32'(d), 0);
        chk("R1 table_sel", 32'(table_sel), 0);
        rd(5'd1, d);  chk("R1 ack", 32'(d), 0);
        rd(a_en(0), d);  chk("R1 en0", 32'(d), 0);
        rd(a_fl(11), d); chk("R1 flag11", 32'(d), 0);

        wr(5'd0, 16'h0001);
        chk("R9 table_sel on", 32'(table_sel), 1);

        // Table-driven main pass.
        for (int k = 0; k < 8; k++) begin
            int g, w;
            logic [7:0] m, e;
            g = int'(TBL[k][22:19]); m = TBL[k][18:11]; e = TBL[k][10:3]; w = int'(TBL[k][2:0]);
            clr_pulses();
            wr(a_en(g), {8'h00, e});
            raise(g, m);
            tick();
            rd(a_fl(g), d);  chk("R2 flag latch", 32'(d), 32'(m));
            chk("R5 one pulse", 32'(pulse_cnt[g]), 1);
            rd(5'd1, d);     chk("R5 ack reads 1", 32'(d[g]), 1);
            fetch(g, h, v);
            chk("R7 hit", 32'(h), 1);
            chk("R7 vector", 32'(v), 32'(exp_vec(g, w)));
            rd(a_fl(g), d);  chk("R8 winner cleared", 32'(d), 32'(m & ~(8'h01 << w)));
            wr(a_fl(g), 16'h0000);
            wr(5'd1, 16'(1 << g));
            wr(a_en(g), 16'h0000);
            tick();
            chk("R6 no extra pulse", 32'(pulse_cnt[g]), 1);
        end
        // R10 readback after last table fetch (group 2, source 4)
        rd(5'd0, d); chk("R10 ctrl readback", 32'(d), 32'(exp_vec(2, 4) | 16'h1));

        // R4 disabled source, upper enable bits
        clr_pulses();
        wr(a_en(9), 16'hFF00);
        raise(9, 8'h01);
        tick(); tick();
        chk("R4 disabled no pulse", 32'(pulse_cnt[9]), 0);
        rd(a_en(9), d); chk("R4 enable upper zero", 32'(d), 0);
        wr(a_en(9), 16'hFFFF);
        rd(a_en(9), d); chk("R4 enable readback", 32'(d), 32'h00FF);
        wr(a_fl(9), 16'h0000);
        wr(5'd1, 16'(1 << 9));
        wr(a_en(9), 16'h0000);

        // R6 blocking and release
        clr_pulses();
        wr(a_en(4), 16'h0003);
        raise(4, 8'h01);
        tick(); tick();
        chk("R5 first pulse", 32'(pulse_cnt[4]), 1);
        raise(4, 8'h02);
        tick(); tick();
        chk("R6 blocked", 32'(pulse_cnt[4]), 1);
        wr(5'd1, 16'h0000);
        rd(5'd1, d); chk("R6 write 0 ignored", 32'(d), 32'h0010);
        tick();
        chk("R6 still blocked", 32'(pulse_cnt[4]), 1);
        wr(5'd1, 16'h0010);
        tick(); tick();
        chk("R6 pulse after release", 32'(pulse_cnt[4]), 2);
        rd(5'd1, d); chk("R6 reblocked", 32'(d), 32'h0010);
        wr(a_fl(4), 16'h0000);
        wr(5'd1, 16'h0010);
        wr(a_en(4), 16'h0000);

        // R3 set wins over write 0; R2 held level
        reg_wr = 1'b1; reg_addr = a_fl(1); reg_wdata = 16'h0000;
        src_irq[1*SRCS + 2] = 1'b1;
        tick();
        reg_wr = 1'b0;
        rd(a_fl(1), d); chk("R3 set wins", 32'(d), 32'h0004);
        wr(a_fl(1), 16'h0000);
        tick();
        rd(a_fl(1), d); chk("R2 level no reset", 32'(d), 0);
        src_irq[1*SRCS + 2] = 1'b0;
        wr(a_fl(1), 16'hFF00);
        rd(a_fl(1), d); chk("R3 upper zero", 32'(d), 0);
        wr(a_fl(1), 16'h0041);
        rd(a_fl(1), d); chk("R3 write 1 sets", 32'(d), 32'h0041);
        wr(a_fl(1), 16'h0000);

        // R9 bypass: fetch changes nothing
        wr(5'd0, 16'h0000);
        chk("R9 table_sel off", 32'(table_sel), 0);
        wr(a_en(6), 16'h0001);
        raise(6, 8'h01);
        tick();
        fetch(6, h, v);
        chk("R9 no hit bypass", 32'(h), 0);
        rd(a_fl(6), d); chk("R9 flag kept", 32'(d), 1);
        rd(5'd0, d);    chk("R9 ctrl kept", 32'(d), 32'(exp_vec(2, 4)));
        wr(5'd0, 16'h0001);
        fetch(6, h, v);
        chk("R7 hit after enable", 32'(h), 1);
        chk("R7 vector g6", 32'(v), 32'(exp_vec(6, 0)));
        rd(5'd0, d); chk("R10 new readback", 32'(d), 32'(exp_vec(6, 0) | 16'h1));
        wr(5'd0, 16'hFFFE);
        rd(5'd0, d); chk("R10 upper read only", 32'(d), 32'(exp_vec(6, 0)));
        wr(5'd0, 16'h0001);
        fetch(6, h, v);
        chk("R7 nothing pending", 32'(h), 0);
        wr(5'd1, 16'h0040);
        wr(a_en(6), 16'h0000);

        // R11 map edges
        wr(5'd1, 16'hFFFF);
        rd(5'd1, d); chk("R11 ack upper zero", 32'(d), 0);
        rd(5'd31, d); chk("R11 unmapped", 32'(d), 0);
        rd(5'd26, d); chk("R11 unmapped 26", 32'(d), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule